// File: doc/BRIEF.md
# Dual-Context Configuration Register Bank

This block keeps two complete copies of the configuration state that steers a content-addressable lookup engine. One copy serves as the foreground context and the other as the background context. Each copy holds six registers: a control word, a segment-control word, an entry address pointer, a compare mask, and a persistent source selector and a persistent destination selector. Only one copy is active at any time. The datapath sees only the active copy's values on the `act_*` outputs. Register writes and readback also reach only the active copy.

A one-cycle `ctx_swap` pulse makes the other copy active. The same pulse clears the sticky match condition, so a lookup result found under one context never leaks into the other. The active address pointer can be loaded directly. Each `mem_access` pulse can also step it up or down, as the control word selects, so table scans need no software reload. The pointer wraps around at both ends of the entry range.

All pins are plain single-cycle strobes and levels. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. Every strobe takes effect at the next rising clock edge. `ENTRIES` must be a power of two, and `DW` must be at least 16.

Top module: `cfg_ctx_bank`

## Requirements
- R1: While `rst_n` is low, and after it is released, context 0 is active, `match_flag` is 0, and all six registers in both contexts read as zero.
- R2: A write (`wr_en`=1) stores into the active context only, using register codes 0=control, 1=segment, 2=address (low `AW` bits), 3=mask, 4=source, 5=destination. `rd_data` shows the active context's register named by `rd_sel`. Codes 6 and 7 are ignored on write and read back as zero.
- R3: `ctx_swap` makes the other context active at the next edge. Both contexts keep their register contents across any number of swaps.
- R4: `ctx_swap` clears `match_flag` at the next edge, even when `match_hit` is high in the same cycle.
- R5: `match_hit` sets `match_flag` only when control bit 2 of the active context is 1. The flag then stays set until it is cleared.
- R6: On `mem_access`, control bits [1:0] of the active context select the address update: 01 adds one, 10 subtracts one, 00 and 11 leave the address unchanged. The address of the inactive context never moves.
- R7: Stepping up from `ENTRIES-1` gives 0. Stepping down from 0 gives `ENTRIES-1`.
- R8: When an address write and `mem_access` occur in the same cycle, the written value is stored and no step is applied.
- R9: A control write with bit 15 set clears all six registers of the active context and `match_flag`. This takes priority over an access in the same cycle. The other context is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register code for the write |
| wr_data | input | DW | Write data |
| rd_sel | input | 3 | Register code for readback |
| rd_data | output | DW | Readback of the active context's register |
| ctx_swap | input | 1 | Toggle the active context and clear the match condition |
| mem_access | input | 1 | One memory access completed; may step the address |
| match_hit | input | 1 | Compare result from the array |
| active_ctx | output | 1 | Index of the active context |
| match_flag | output | 1 | Sticky match condition |
| act_ctl | output | DW | Active control register |
| act_seg | output | DW | Active segment-control register |
| act_addr | output | AW | Active address pointer |
| act_mask | output | DW | Active mask register |
| act_src | output | DW | Active persistent source register |
| act_dst | output | DW | Active persistent destination register |

## Verification
The assertions check the following on every cycle:
- a context that gets neither a write nor a step keeps all of its registers;
- the two address wraps;
- the hold modes;
- the clear command;
- the toggle and match clear on a swap;
- a disabled match enable never raising the flag.

Some behaviour only the bench scenarios can show. That includes:
- whether the values a swap reveals really are the ones stored before it;
- write-versus-access and clear-versus-hit priority against exact data;
- readback through every register code.

// File: rtl/cfg_ctx_pkg.sv
package cfg_ctx_pkg;
  typedef enum logic [2:0] {
    RS_CTL  = 3'd0,
    RS_SEG  = 3'd1,
    RS_ADDR = 3'd2,
    RS_MASK = 3'd3,
    RS_SRC  = 3'd4,
    RS_DST  = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    AM_HOLD  = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_HOLD2 = 2'd3
  } addr_mode_e;

  localparam int CTL_MEN_BIT = 2;
  localparam int CTL_CLR_BIT = 15;
endpackage

// File: rtl/cfg_addr_step.sv
module cfg_addr_step #(
  parameter int ENTRIES = 1024,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  output logic [AW-1:0] nxt
);
  import cfg_ctx_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

  always_comb begin
    case (addr_mode_e'(mode))
      AM_INC:  nxt = (addr == LAST) ? '0 : addr + 1'b1;
      AM_DEC:  nxt = (addr == '0) ? LAST : addr - 1'b1;
      default: nxt = addr;
    endcase
  end
endmodule

// File: rtl/cfg_ctx_set.sv
module cfg_ctx_set #(
  parameter int DW      = 16,
  parameter int ENTRIES = 1024,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    wsel,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  output logic [DW-1:0] ctl_q,
  output logic [DW-1:0] seg_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] dst_q
);
  import cfg_ctx_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

  logic [AW-1:0] addr_nxt;
  logic          clr;
  logic          addr_wr;

  cfg_addr_step #(.ENTRIES(ENTRIES), .AW(AW)) u_step (
    .addr(addr_q), .mode(ctl_q[1:0]), .nxt(addr_nxt)
  );

  assign clr     = we && (wsel == RS_CTL) && wdata[CTL_CLR_BIT];
  assign addr_wr = we && (wsel == RS_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; seg_q <= '0; addr_q <= '0;
      mask_q <= '0; src_q <= '0; dst_q <= '0;
    end else if (clr) begin
      ctl_q <= '0; seg_q <= '0; addr_q <= '0;
      mask_q <= '0; src_q <= '0; dst_q <= '0;
    end else begin
      if (we) begin
        case (reg_sel_e'(wsel))
          RS_CTL:  ctl_q  <= wdata;
          RS_SEG:  seg_q  <= wdata;
          RS_MASK: mask_q <= wdata;
          RS_SRC:  src_q  <= wdata;
          RS_DST:  dst_q  <= wdata;
          default: ;
        endcase
      end
      if (addr_wr)   addr_q <= wdata[AW-1:0];
      else if (step) addr_q <= addr_nxt;
    end
  end

  // R2 / R6: an untouched context holds every register
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !step) |=> ($stable(ctl_q) && $stable(seg_q) && $stable(addr_q)
                        && $stable(mask_q) && $stable(src_q) && $stable(dst_q)));
  a_r7_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we && ctl_q[1:0] == 2'b01 && addr_q == LAST) |=> (addr_q == '0));
  a_r7_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we && ctl_q[1:0] == 2'b10 && addr_q == '0) |=> (addr_q == LAST));
  a_r6_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !we && (ctl_q[1:0] == 2'b00 || ctl_q[1:0] == 2'b11)) |=> $stable(addr_q));
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctl_q == '0 && seg_q == '0 && addr_q == '0 && mask_q == '0
             && src_q == '0 && dst_q == '0));
endmodule

// File: rtl/cfg_ctx_bank.sv
module cfg_ctx_bank #(
  parameter int DW      = 16,
  parameter int ENTRIES = 1024,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          ctx_swap,
  input  logic          mem_access,
  input  logic          match_hit,
  output logic          active_ctx,
  output logic          match_flag,
  output logic [DW-1:0] act_ctl,
  output logic [DW-1:0] act_seg,
  output logic [AW-1:0] act_addr,
  output logic [DW-1:0] act_mask,
  output logic [DW-1:0] act_src,
  output logic [DW-1:0] act_dst
);
  import cfg_ctx_pkg::*;
  localparam int NCTX = 2;

  logic [DW-1:0] ctl_v  [NCTX];
  logic [DW-1:0] seg_v  [NCTX];
  logic [AW-1:0] addr_v [NCTX];
  logic [DW-1:0] mask_v [NCTX];
  logic [DW-1:0] src_v  [NCTX];
  logic [DW-1:0] dst_v  [NCTX];
  logic          act_q;
  logic          match_q;
  logic          soft_clr;

  for (genvar g = 0; g < NCTX; g++) begin : g_ctx
    cfg_ctx_set #(.DW(DW), .ENTRIES(ENTRIES), .AW(AW)) u_set (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && (act_q == 1'(g))), .wsel(wr_sel), .wdata(wr_data),
      .step(mem_access && (act_q == 1'(g))),
      .ctl_q(ctl_v[g]), .seg_q(seg_v[g]), .addr_q(addr_v[g]),
      .mask_q(mask_v[g]), .src_q(src_v[g]), .dst_q(dst_v[g])
    );
  end

  assign act_ctl  = ctl_v[act_q];
  assign act_seg  = seg_v[act_q];
  assign act_addr = addr_v[act_q];
  assign act_mask = mask_v[act_q];
  assign act_src  = src_v[act_q];
  assign act_dst  = dst_v[act_q];
  assign active_ctx = act_q;
  assign match_flag = match_q;
  assign soft_clr = wr_en && (wr_sel == RS_CTL) && wr_data[CTL_CLR_BIT];

  always_comb begin
    case (reg_sel_e'(rd_sel))
      RS_CTL:  rd_data = act_ctl;
      RS_SEG:  rd_data = act_seg;
      RS_ADDR: rd_data = DW'(act_addr);
      RS_MASK: rd_data = act_mask;
      RS_SRC:  rd_data = act_src;
      RS_DST:  rd_data = act_dst;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (ctx_swap) act_q <= ~act_q;
      if (ctx_swap || soft_clr)                      match_q <= 1'b0;
      else if (match_hit && act_ctl[CTL_MEN_BIT])    match_q <= 1'b1;
    end
  end

  a_r3_swap_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_swap |=> (active_ctx != $past(active_ctx)));
  a_r3_no_spurious_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_swap |=> $stable(active_ctx));
  a_r4_swap_clears_match: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_swap |=> !match_flag);
  a_r5_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!match_flag && !(match_hit && act_ctl[CTL_MEN_BIT])) |=> !match_flag);
endmodule

// File: tb/cfg_ctx_bank_test.sv
module cfg_ctx_bank_test;
  localparam int DW = 16;
  localparam int ENTRIES = 1024;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, ctx_swap = 0, mem_access = 0, match_hit = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic active_ctx, match_flag;
  logic [DW-1:0] act_ctl, act_seg, act_mask, act_src, act_dst;
  logic [AW-1:0] act_addr;

  int checks = 0, failures = 0;
  logic [15:0] m [2][6];
  logic m_act, m_match;

  always #2 clk = ~clk;

  cfg_ctx_bank #(.DW(DW), .ENTRIES(ENTRIES), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ctx_swap(ctx_swap), .mem_access(mem_access),
    .match_hit(match_hit), .active_ctx(active_ctx), .match_flag(match_flag),
    .act_ctl(act_ctl), .act_seg(act_seg), .act_addr(act_addr), .act_mask(act_mask),
    .act_src(act_src), .act_dst(act_dst));

  task automatic check(input string req, input string what, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, a, e);
    end
  endtask

  function automatic logic [15:0] next_addr(input logic [15:0] a, input logic [1:0] md);
    case (md)
      2'b01: return (a == ENTRIES - 1) ? 16'd0 : a + 16'd1;
      2'b10: return (a == 0) ? 16'(ENTRIES - 1) : a - 16'd1;
      default: return a;
    endcase
  endfunction

  task automatic compare_all(input string req);
    check(req, "ctx", 32'(active_ctx), 32'(m_act));
    check(req, "match", 32'(match_flag), 32'(m_match));
    check(req, "ctl", 32'(act_ctl), 32'(m[m_act][0]));
    check(req, "seg", 32'(act_seg), 32'(m[m_act][1]));
    check(req, "addr", 32'(act_addr), 32'(m[m_act][2]));
    check(req, "mask", 32'(act_mask), 32'(m[m_act][3]));
    check(req, "src", 32'(act_src), 32'(m[m_act][4]));
    check(req, "dst", 32'(act_dst), 32'(m[m_act][5]));
    check(req, "rd", 32'(rd_data), (rd_sel < 6) ? 32'(m[m_act][rd_sel]) : 32'd0);
  endtask

  task automatic cyc(input string req, input logic we, input logic [2:0] sel,
                     input logic [15:0] d, input logic sw, input logic ac,
                     input logic ht, input logic [2:0] rs);
    logic clr, men;
    logic [1:0] md;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; ctx_swap = sw;
    mem_access = ac; match_hit = ht; rd_sel = rs;
    clr = we && sel == 0 && d[15];
    md = m[m_act][0][1:0];
    men = m[m_act][0][2];
    if (clr) begin
      for (int i = 0; i < 6; i++) m[m_act][i] = 16'd0;
    end else begin
      if (we && sel < 6 && sel != 2) m[m_act][sel] = d;
      if (we && sel == 2) m[m_act][2] = d & 16'h03ff;
      else if (ac) m[m_act][2] = next_addr(m[m_act][2], md);
    end
    if (sw || clr) m_match = 1'b0;
    else if (ht && men) m_match = 1'b1;
    if (sw) m_act = ~m_act;
    @(posedge clk); #1;
    compare_all(req);
  endtask

  initial begin
    int cyc_n = 0;
    forever begin
      @(posedge clk);
      cyc_n++;
      if (cyc_n > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 2; c++) for (int i = 0; i < 6; i++) m[c][i] = 16'd0;
    m_act = 0; m_match = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1: values held during reset
    compare_all("R1");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      rd_sel = 3'(i); #1; compare_all("R1");
    end
    // R2: writes and readback, unknown codes
    cyc("R2", 1, 3, 16'hA5A5, 0, 0, 0, 3);
    cyc("R2", 1, 4, 16'h0F0F, 0, 0, 0, 4);
    cyc("R2", 1, 6, 16'hFFFF, 0, 0, 0, 6);
    cyc("R2", 1, 7, 16'h7777, 0, 0, 0, 7);
    // R3: other context untouched, retained across swaps
    cyc("R3", 0, 0, 0, 1, 0, 0, 3);
    cyc("R3", 1, 3, 16'h1234, 0, 0, 0, 3);
    cyc("R3", 0, 0, 0, 1, 0, 0, 3);
    cyc("R3", 0, 0, 0, 1, 0, 0, 3);
    cyc("R3", 0, 0, 0, 1, 0, 0, 4);
    // R7: wraps
    cyc("R7", 1, 0, 16'h0001, 0, 0, 0, 0);
    cyc("R7", 1, 2, 16'd1023, 0, 0, 0, 2);
    cyc("R7", 0, 0, 0, 0, 1, 0, 2);
    cyc("R7", 1, 0, 16'h0002, 0, 0, 0, 2);
    cyc("R7", 0, 0, 0, 0, 1, 0, 2);
    // R6: hold modes and stepping
    cyc("R6", 0, 0, 0, 0, 1, 0, 2);
    cyc("R6", 1, 0, 16'h0000, 0, 0, 0, 2);
    cyc("R6", 0, 0, 0, 0, 1, 0, 2);
    cyc("R6", 1, 0, 16'h0003, 0, 1, 0, 2);
    cyc("R6", 0, 0, 0, 0, 1, 0, 2);
    // R8: load beats step
    cyc("R8", 1, 0, 16'h0001, 0, 0, 0, 2);
    cyc("R8", 1, 2, 16'd5, 0, 1, 0, 2);
    cyc("R8", 0, 0, 0, 0, 1, 0, 2);
    // R5: match enable
    cyc("R5", 1, 0, 16'h0000, 0, 0, 1, 0);
    cyc("R5", 1, 0, 16'h0004, 0, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0, 1, 0);
    cyc("R5", 0, 0, 0, 0, 0, 0, 0);
    // R4: swap clears, even with hit
    cyc("R4", 0, 0, 0, 1, 0, 1, 0);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0);
    cyc("R4", 0, 0, 0, 0, 0, 1, 0);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0);
    cyc("R4", 0, 0, 0, 1, 0, 0, 0);
    // R9: clear command
    cyc("R9", 1, 1, 16'hBEEF, 0, 0, 0, 1);
    cyc("R9", 0, 0, 0, 0, 0, 1, 1);
    cyc("R9", 1, 0, 16'h8001, 0, 1, 1, 1);
    cyc("R9", 0, 0, 0, 1, 0, 0, 3);
    cyc("R9", 0, 0, 0, 1, 0, 0, 3);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      logic [15:0] d;
      s = 3'($urandom % 8);
      d = 16'($urandom);
      if (s == 0) begin
        d[2:0] = 3'($urandom % 8);
        if ($urandom % 16 != 0) d[15] = 1'b0;
      end
      if (s == 2 && ($urandom % 4 == 0)) d = ($urandom % 2) ? 16'd1023 : 16'd0;
      cyc("R2", ($urandom % 10) < 4, s, d, ($urandom % 8) == 0,
          ($urandom % 10) < 5, ($urandom % 10) < 3, 3'($urandom % 8));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule